// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a processor core and its data memory and lets stores retire early. Each accepted store is parked in a small queue and written to memory later through a valid/ready write channel, one queue entry per accepted transfer. Loads do not wait for that queue to empty. A load whose word is held in the queue is answered from the queue, using the newest matching store. A load whose word is not held there reads memory directly, even while older stores are still queued.

Every entry covers one line of four words and carries a per-word valid mask. In the default mode each store takes a fresh entry, and entries reach memory in the order the stores were accepted. When the merge input is high, a store that hits the line of a queued entry is folded into that entry instead, so lines can overtake one another on their way to memory. The entry currently offered to memory is never merged into. A fence request stalls all later loads and stores until every earlier store has been written.

Top module: `store_fwd_buf`

## Requirements
- R1: After reset the queue is empty and any pending fence is cleared: `mem_wr_valid`=0, `fence_busy`=0, `st_ready`=1, `ld_ready`=1, `ld_resp_valid`=0.
- R2: With `merge_en`=0, every accepted store becomes its own memory write. Writes leave in acceptance order, each with line address `addr[ADDR_W-1:2]` and mask bit `addr[1:0]` set (bit i selects word i, which is data bits `[32*i+:32]` at the default width).
- R3: A load that matches no queued word drives `mem_rd_en` in its accept cycle. It completes with `ld_resp_valid` one cycle later, carrying `mem_rd_data`, even while older stores wait in the queue.
- R4: A load whose word is held in the queue returns the queued data one cycle after it is accepted, not the memory value.
- R5: When several queued entries hold the load's word, the data comes from the most recently accepted store.
- R6: The queue holds `DEPTH` (8) entries. `st_ready` is 0 while all entries are occupied, and a store offered in that state is accepted later rather than lost.
- R7: A `fence_req` pulse raises `fence_busy` on the next cycle. While `fence_busy` is high, `st_ready` and `ld_ready` are 0. `fence_busy` falls one cycle after the queue becomes empty, so every store accepted before the fence is already in memory.
- R8: With `merge_en`=1, a store whose line matches a queued entry other than the one offered to memory is merged into that entry: its mask bit is set and the word is overwritten. Its data therefore reaches memory ahead of stores to other lines that were accepted earlier.
- R9: The head entry leaves only when `mem_wr_valid` and `mem_wr_ready` are both 1. While the write is refused, its line, data and mask hold steady.
- R10: Forwarding requires the word's mask bit. A load to an unwritten word of a queued line is served from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| merge_en | input | 1 | Selects merge mode; changed only while the queue is empty |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load can be accepted this cycle |
| ld_addr | input | ADDR_W | Load word address |
| ld_resp_valid | output | 1 | Load result present |
| ld_resp_data | output | DATA_W | Load result |
| fence_req | input | 1 | Fence pulse |
| fence_busy | output | 1 | Fence waiting for the queue to drain |
| mem_wr_valid | output | 1 | Head entry offered to memory |
| mem_wr_ready | input | 1 | Memory accepts the offered entry |
| mem_wr_line | output | ADDR_W-log2(LINE_WORDS) | Line address of the offered entry |
| mem_wr_data | output | LINE_WORDS*DATA_W | Line data, word i at bits [DATA_W*i +: DATA_W] |
| mem_wr_mask | output | LINE_WORDS | Words of the line to write |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read word address |
| mem_rd_data | input | DATA_W | Read data, valid the cycle after `mem_rd_en` |

## Verification
The properties assume the memory returns read data exactly one cycle after `mem_rd_en`, and that the merge input only changes while the queue is empty. They also assume no load is offered in the same cycle as a store to the same word, since the order between the two would be undefined. The bench model answers reads with a one-cycle registered array and toggles `merge_en` only between scenarios, after a full drain. It offers loads and stores one at a time, so they never collide in the same cycle. The bench holds `mem_wr_ready` low to keep stores queued while loads and fences are exercised.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  // Where a completed load took its data from
  typedef enum logic {
    SRC_MEM = 1'b0,
    SRC_BUF = 1'b1
  } ld_src_e;
endpackage

// File: rtl/sfb_match.sv
// Searches the occupied queue slots, oldest to newest, and reports the
// newest slot whose line tag matches (and optionally whose word is valid).
module sfb_match #(
  parameter int DEPTH      = 8,
  parameter int TAG_W      = 10,
  parameter int LINE_WORDS = 4
) (
  input  logic [DEPTH-1:0][TAG_W-1:0]      tags,
  input  logic [DEPTH-1:0][LINE_WORDS-1:0] masks,
  input  logic [$clog2(DEPTH)-1:0]         head,
  input  logic [$clog2(DEPTH):0]           count,
  input  logic [TAG_W-1:0]                 probe_tag,
  input  logic [$clog2(LINE_WORDS)-1:0]    probe_word,
  input  logic                             skip_head,
  input  logic                             use_mask,
  output logic                             hit,
  output logic [$clog2(DEPTH)-1:0]         idx
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DEPTH-1:0]            cand;
  logic [DEPTH-1:0][PTR_W-1:0] slot;

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign slot[k] = head + PTR_W'(k);
    assign cand[k] = (CNT_W'(k) < count)
                   && !(skip_head && (k == 0))
                   && (tags[slot[k]] == probe_tag)
                   && (!use_mask || masks[slot[k]][probe_word]);
  end

  // later (younger) candidates override earlier ones
  always_comb begin
    hit = 1'b0;
    idx = head;
    for (int k = 0; k < DEPTH; k++) begin
      if (cand[k]) begin
        hit = 1'b1;
        idx = slot[k];
      end
    end
  end
endmodule

// File: rtl/sfb_fence.sv
module sfb_fence (
  input  logic clk,
  input  logic rst,
  input  logic fence_req,
  input  logic buf_empty,
  output logic busy
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst)                     busy_q <= 1'b0;
    else if (fence_req)          busy_q <= 1'b1;
    else if (busy_q && buf_empty) busy_q <= 1'b0;
  end

  assign busy = busy_q;

  // R7: a fence cannot release while stores remain queued
  p_fence_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !buf_empty) |=> busy);

  // R7: release happens only after an empty queue was observed
  p_fence_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(buf_empty));
endmodule

// File: rtl/sfb_load_port.sv
module sfb_load_port
  import sfb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_fire,
  input  logic              buf_hit,
  input  logic [DATA_W-1:0] buf_data,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_rd_en,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);
  logic              resp_v_q;
  ld_src_e           src_q;
  logic [DATA_W-1:0] fwd_q;

  assign mem_rd_en = ld_fire && !buf_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_v_q <= 1'b0;
      src_q    <= SRC_MEM;
    end else begin
      resp_v_q <= ld_fire;
      src_q    <= buf_hit ? SRC_BUF : SRC_MEM;
    end
    fwd_q <= buf_data;
  end

  assign resp_valid = resp_v_q;
  assign resp_data  = (src_q == SRC_BUF) ? fwd_q : mem_rd_data;

  // R3: every accepted load completes on the following cycle
  p_resp_next_r3: assert property (@(posedge clk) disable iff (rst)
    ld_fire |=> resp_valid);

  // R3: a memory read is answered with memory data, not queued data
  p_miss_from_mem_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> (src_q == SRC_MEM));
endmodule

// File: rtl/store_fwd_buf.sv
module store_fwd_buf #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 8,
  parameter int LINE_WORDS = 4
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     merge_en,
  input  logic                                     st_valid,
  output logic                                     st_ready,
  input  logic [ADDR_W-1:0]                        st_addr,
  input  logic [DATA_W-1:0]                        st_data,
  input  logic                                     ld_valid,
  output logic                                     ld_ready,
  input  logic [ADDR_W-1:0]                        ld_addr,
  output logic                                     ld_resp_valid,
  output logic [DATA_W-1:0]                        ld_resp_data,
  input  logic                                     fence_req,
  output logic                                     fence_busy,
  output logic                                     mem_wr_valid,
  input  logic                                     mem_wr_ready,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]     mem_wr_line,
  output logic [LINE_WORDS*DATA_W-1:0]             mem_wr_data,
  output logic [LINE_WORDS-1:0]                    mem_wr_mask,
  output logic                                     mem_rd_en,
  output logic [ADDR_W-1:0]                        mem_rd_addr,
  input  logic [DATA_W-1:0]                        mem_rd_data
);
  localparam int WIDX_W = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - WIDX_W;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = PTR_W + 1;

  // queue storage
  logic [DEPTH-1:0][TAG_W-1:0]          tag_q;
  logic [DEPTH-1:0][LINE_WORDS-1:0]     mask_q;
  logic [LINE_WORDS-1:0][DATA_W-1:0]    data_q [DEPTH];
  logic [PTR_W-1:0]                     head_q, tail_q;
  logic [CNT_W-1:0]                     count_q;

  logic [TAG_W-1:0]  st_tag, ld_tag;
  logic [WIDX_W-1:0] st_word, ld_word;
  logic              full, empty;
  logic              st_fire, ld_fire, push, pop;
  logic              mrg_hit_raw, mrg_hit, fwd_hit;
  logic [PTR_W-1:0]  mrg_idx, fwd_idx;
  logic [DATA_W-1:0] fwd_data;

  assign st_tag  = st_addr[ADDR_W-1:WIDX_W];
  assign st_word = st_addr[WIDX_W-1:0];
  assign ld_tag  = ld_addr[ADDR_W-1:WIDX_W];
  assign ld_word = ld_addr[WIDX_W-1:0];

  assign full  = (count_q == CNT_W'(DEPTH));
  assign empty = (count_q == '0);

  // merge target: same line, never the entry offered to memory
  sfb_match #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS)) i_merge_match (
    .tags(tag_q), .masks(mask_q), .head(head_q), .count(count_q),
    .probe_tag(st_tag), .probe_word(st_word),
    .skip_head(1'b1), .use_mask(1'b0),
    .hit(mrg_hit_raw), .idx(mrg_idx)
  );

  // forwarding source: same line and word valid, youngest wins
  sfb_match #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LINE_WORDS(LINE_WORDS)) i_fwd_match (
    .tags(tag_q), .masks(mask_q), .head(head_q), .count(count_q),
    .probe_tag(ld_tag), .probe_word(ld_word),
    .skip_head(1'b0), .use_mask(1'b1),
    .hit(fwd_hit), .idx(fwd_idx)
  );

  assign mrg_hit  = merge_en && mrg_hit_raw;
  assign fwd_data = data_q[fwd_idx][ld_word];

  assign st_ready = !full && !fence_busy;
  assign ld_ready = !fence_busy;
  assign st_fire  = st_valid && st_ready;
  assign ld_fire  = ld_valid && ld_ready;
  assign push     = st_fire && !mrg_hit;
  assign pop      = mem_wr_valid && mem_wr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      mask_q  <= '0;
    end else begin
      if (push) begin
        tag_q[tail_q]  <= st_tag;
        mask_q[tail_q] <= LINE_WORDS'(1) << st_word;
        tail_q         <= tail_q + 1'b1;
      end else if (st_fire) begin
        mask_q[mrg_idx][st_word] <= 1'b1;
      end
      if (pop) head_q <= head_q + 1'b1;
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // data words carry no reset so the array stays plain storage
  always_ff @(posedge clk) begin
    if (push)         data_q[tail_q][st_word]  <= st_data;
    else if (st_fire) data_q[mrg_idx][st_word] <= st_data;
  end

  assign mem_wr_valid = !empty;
  assign mem_wr_line  = tag_q[head_q];
  assign mem_wr_data  = data_q[head_q];
  assign mem_wr_mask  = mask_q[head_q];

  sfb_fence i_fence (
    .clk(clk), .rst(rst), .fence_req(fence_req),
    .buf_empty(empty), .busy(fence_busy)
  );

  assign mem_rd_addr = ld_addr;

  sfb_load_port #(.DATA_W(DATA_W)) i_load (
    .clk(clk), .rst(rst), .ld_fire(ld_fire), .buf_hit(fwd_hit),
    .buf_data(fwd_data), .mem_rd_data(mem_rd_data),
    .mem_rd_en(mem_rd_en), .resp_valid(ld_resp_valid), .resp_data(ld_resp_data)
  );

  // R6: occupancy never exceeds the queue depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  // R9: a refused write keeps offering the same entry unchanged
  p_head_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_line) && $stable(mem_wr_data) && $stable(mem_wr_mask)));

  // R2: without merging, each accepted store adds exactly one entry
  p_fifo_grow_r2: assert property (@(posedge clk) disable iff (rst)
    (st_fire && !merge_en && !pop) |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: tb/test_store_fwd_buf.sv
module test_store_fwd_buf;
  localparam int AW = 8;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           merge_en = 1'b0;
  logic           st_valid = 1'b0, st_ready;
  logic [AW-1:0]  st_addr = '0;
  logic [DW-1:0]  st_data = '0;
  logic           ld_valid = 1'b0, ld_ready;
  logic [AW-1:0]  ld_addr = '0;
  logic           ld_resp_valid;
  logic [DW-1:0]  ld_resp_data;
  logic           fence_req = 1'b0, fence_busy;
  logic           mem_wr_valid, wr_ready = 1'b1;
  logic [AW-3:0]  mem_wr_line;
  logic [4*DW-1:0] mem_wr_data;
  logic [3:0]     mem_wr_mask;
  logic           mem_rd_en;
  logic [AW-1:0]  mem_rd_addr;
  logic [DW-1:0]  mem_rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0]  mem [256];
  logic [AW-3:0]  log_line [64];
  logic [3:0]     log_mask [64];
  int             log_n = 0;

  always #4 clk = ~clk;

  store_fwd_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(8), .LINE_WORDS(4)) i_store_fwd_buf (
    .clk(clk), .rst(rst), .merge_en(merge_en),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_resp_valid(ld_resp_valid), .ld_resp_data(ld_resp_data),
    .fence_req(fence_req), .fence_busy(fence_busy),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(wr_ready), .mem_wr_line(mem_wr_line),
    .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;

  // memory model: one-cycle read, masked line write, write log
  always @(posedge clk) begin
    if (!rst && mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    if (!rst && mem_wr_valid && wr_ready) begin
      for (int w = 0; w < 4; w++)
        if (mem_wr_mask[w]) mem[{mem_wr_line, 2'(w)}] <= mem_wr_data[w*DW +: DW];
      log_line[log_n] <= mem_wr_line;
      log_mask[log_n] <= mem_wr_mask;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, output logic v, output logic [DW-1:0] d);
    ld_valid = 1'b1; ld_addr = a;
    while (!ld_ready) @(negedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    v = ld_resp_valid;
    d = ld_resp_data;
  endtask

  task automatic wait_drain();
    while (mem_wr_valid) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mem_wr_valid", mem_wr_valid, 0);
    chk("R1 fence_busy", fence_busy, 0);
    chk("R1 st_ready", st_ready, 1);
    chk("R1 ld_ready", ld_ready, 1);
    chk("R1 ld_resp_valid", ld_resp_valid, 0);
  endtask

  task automatic t_fifo_forward();
    int base;
    logic v; logic [DW-1:0] d;
    base = log_n;
    wr_ready = 1'b0;
    do_store(8'h10, 32'hD1);
    do_store(8'h24, 32'hD2);
    do_store(8'h11, 32'hD3);
    repeat (3) @(negedge clk);
    chk("R9 head offered", mem_wr_valid, 1);
    chk("R9 head line", mem_wr_line, 6'h04);
    chk("R9 head mask", mem_wr_mask, 4'b0001);
    chk("R9 nothing written", log_n - base, 0);
    do_load(8'h30, v, d);
    chk("R3 miss valid", v, 1);
    chk("R3 miss data", d, 32'hA000_0030);
    chk("R3 stores still queued", mem_wr_valid, 1);
    do_load(8'h24, v, d);
    chk("R4 hit data", d, 32'hD2);
    do_store(8'h10, 32'hD4);
    do_load(8'h10, v, d);
    chk("R5 youngest match", d, 32'hD4);
    wr_ready = 1'b1;
    wait_drain();
    chk("R2 write count", log_n - base, 4);
    chk("R2 order 0", {log_line[base],   log_mask[base]},   {6'h04, 4'b0001});
    chk("R2 order 1", {log_line[base+1], log_mask[base+1]}, {6'h09, 4'b0001});
    chk("R2 order 2", {log_line[base+2], log_mask[base+2]}, {6'h04, 4'b0010});
    chk("R2 order 3", {log_line[base+3], log_mask[base+3]}, {6'h04, 4'b0001});
    chk("R2 final word", mem[8'h10], 32'hD4);
    chk("R2 final word 1", mem[8'h11], 32'hD3);
  endtask

  task automatic t_full();
    int base;
    base = log_n;
    wr_ready = 1'b0;
    for (int i = 0; i < 8; i++) do_store(8'(8'h40 + 4*i), 32'hE0 + i);
    chk("R6 full blocks store", st_ready, 0);
    st_valid = 1'b1; st_addr = 8'h60; st_data = 32'hE8;
    repeat (3) @(negedge clk);
    chk("R6 still full", st_ready, 0);
    wr_ready = 1'b1;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 1'b0;
    wait_drain();
    chk("R6 nothing dropped", log_n - base, 9);
    chk("R6 last line", log_line[base+8], 6'h18);
    chk("R6 last data", mem[8'h60], 32'hE8);
    chk("R6 first data", mem[8'h40], 32'hE0);
  endtask

  task automatic t_fence();
    int base;
    base = log_n;
    wr_ready = 1'b0;
    do_store(8'h80, 32'hF1);
    fence_req = 1'b1;
    @(negedge clk);
    fence_req = 1'b0;
    chk("R7 busy raised", fence_busy, 1);
    chk("R7 store held", st_ready, 0);
    chk("R7 load held", ld_ready, 0);
    repeat (3) @(negedge clk);
    chk("R7 still waiting", fence_busy, 1);
    wr_ready = 1'b1;
    while (fence_busy) @(negedge clk);
    chk("R7 store done before release", mem[8'h80], 32'hF1);
    chk("R7 one write", log_n - base, 1);
    fence_req = 1'b1;
    @(negedge clk);
    fence_req = 1'b0;
    chk("R7 empty fence busy", fence_busy, 1);
    @(negedge clk);
    chk("R7 empty fence release", fence_busy, 0);
  endtask

  task automatic t_merge();
    int base;
    logic v; logic [DW-1:0] d;
    base = log_n;
    merge_en = 1'b1;
    wr_ready = 1'b0;
    do_store(8'hA0, 32'hC1);
    do_store(8'hB0, 32'hC2);
    do_store(8'hC0, 32'hC3);
    do_store(8'hB1, 32'hC4);
    do_store(8'hB1, 32'hC5);
    do_store(8'hA1, 32'hC6);
    do_load(8'hB1, v, d);
    chk("R8 merged word forwarded", d, 32'hC5);
    do_load(8'hB2, v, d);
    chk("R10 unwritten word from memory", d, 32'hA000_00B2);
    do_load(8'hA1, v, d);
    chk("R8 head not merged forward", d, 32'hC6);
    wr_ready = 1'b1;
    wait_drain();
    chk("R8 write count", log_n - base, 4);
    chk("R8 entry 0", {log_line[base],   log_mask[base]},   {6'h28, 4'b0001});
    chk("R8 entry 1", {log_line[base+1], log_mask[base+1]}, {6'h2C, 4'b0011});
    chk("R8 entry 2", {log_line[base+2], log_mask[base+2]}, {6'h30, 4'b0001});
    chk("R8 entry 3", {log_line[base+3], log_mask[base+3]}, {6'h28, 4'b0010});
    chk("R8 overwrite kept", mem[8'hB1], 32'hC5);
    chk("R10 untouched word", mem[8'hB2], 32'hA000_00B2);
    merge_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fifo_forward();
    t_full();
    t_fence();
    t_merge();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule